// File: doc/BRIEF.md
# Two-wire bus byte-event master (receive-oriented)

This block is a byte-stepped master for a two-wire serial bus, with open-drain clock and data lines. A CPU drives each transfer one bus event at a time. It can request a START, a repeated START or a STOP. It loads an address byte whose least significant bit picks the direction. In read mode the CPU then asks for data bytes one at a time.

After every event the block raises an event flag and posts an 8-bit status code. It then parks the clock line low until software clears the flag by writing a one to it. Received bytes appear in the data register. The acknowledge bit that the master returns for each byte follows the acknowledge-enable control bit, so software answers the last byte with NACK before it sends STOP or a repeated START.

Bit timing comes from a free-running quarter-bit tick. A START is only launched after both lines have been seen high for a set number of quarter periods. The block releases the bus and reports arbitration loss if it reads a low data line while it is sending a one.

Top module: `twm_master_rx`

## Requirements
- R1: The control read value has these bits: [7] event flag, [6] acknowledge enable, [5] start request, [4] stop request, [3] write-collision flag (read-only), [2] interface enable, [1] always reads 0, [0] interrupt enable. `irq` equals event flag AND interrupt enable.
- R2: After reset the status reads 0xF8 and the control and data registers read 0x00. Both bus lines are released.
- R3: Writing control with bit 7 = 1 clears the event flag, and the next bus action starts only on such a write with bit 2 = 1. A control write with bit 7 = 0 leaves the flag and the status unchanged.
- R4: A START is generated only after SCL and SDA have both been high for BUS_FREE consecutive quarter periods. It then sets the flag with status 0x08, and the start request bit clears itself.
- R5: A START requested while the block still holds the bus is a repeated START and posts status 0x10.
- R6: After status 0x08 or 0x10, a go-write sends the data register as the address byte. With LSB = 1 (read) the status is 0x40 on ACK and 0x48 on NACK. With LSB = 0 (write) it is 0x18 on ACK and 0x20 on NACK.
- R7: After status 0x40 or 0x50, a go-write receives a byte, MSB first, into the data register. The block returns ACK (SDA low) and posts 0x50 if acknowledge enable is 1, or returns NACK and posts 0x58 if it is 0.
- R8: After status 0x18 or 0x28, a go-write sends the data register as a data byte and posts 0x28 on ACK or 0x30 on NACK.
- R9: If SDA reads low while the block is sending a one in an address or data bit, the block releases both lines at once and posts status 0x38 with the flag set.
- R10: A STOP request while holding the bus sends STOP and leaves both lines released. The status becomes 0xF8, the flag stays 0 and the stop request bit clears itself.
- R11: While the event flag is set and the block holds the bus, SCL is driven low.
- R12: A data write while the flag is 0 sets the write-collision flag and leaves the data register unchanged. A data write while the flag is 1 loads the register and clears the write-collision flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Data write value |
| ctl_rdata | output | 8 | Control register read value |
| stat_rdata | output | 8 | Posted status code |
| dat_rdata | output | 8 | Data register (received or to send) |
| irq | output | 1 | Event flag gated by interrupt enable |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_low | output | 1 | Pull SCL low when 1 |
| sda_low | output | 1 | Pull SDA low when 1 |

## Verification
The main function is exercised by seeded random transfers against a bus-slave model. Each transfer varies the direction bit, whether the address matches (ACK or NACK), the byte count, the slave's acknowledge in write mode, and whether it ends with STOP or a repeated START. Together these separate every status code path: 0x40 from 0x48, 0x50 from 0x58, 0x18/0x28 from 0x20/0x30, and 0x08 from 0x10. Directed cases hold SDA low to show that a START waits for a free bus and that a one-bit loss gives 0x38. They also cover data writes with the flag low, control writes without the clear bit, and the acknowledge the slave sees for each received byte, including the final NACK.

// File: rtl/twm_pkg.sv
package twm_pkg;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_TX, OP_RX} op_e;

  typedef enum logic [2:0] {
    K_START, K_RSTART, K_ADDR, K_WDATA, K_RX, K_STOP
  } kind_e;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_W_AACK  = 8'h18;
  localparam logic [7:0] ST_W_ANACK = 8'h20;
  localparam logic [7:0] ST_W_DACK  = 8'h28;
  localparam logic [7:0] ST_W_DNACK = 8'h30;
  localparam logic [7:0] ST_ARB     = 8'h38;
  localparam logic [7:0] ST_R_AACK  = 8'h40;
  localparam logic [7:0] ST_R_ANACK = 8'h48;
  localparam logic [7:0] ST_R_DACK  = 8'h50;
  localparam logic [7:0] ST_R_DNACK = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  // Status encoder: maps a finished event onto its code
  function automatic logic [7:0] post_status(kind_e kind, logic arb, logic ack, logic rd);
    logic [7:0] s;
    case (kind)
      K_START:  s = ST_START;
      K_RSTART: s = ST_RSTART;
      K_ADDR:   s = arb ? ST_ARB : (rd ? (ack ? ST_R_AACK : ST_R_ANACK)
                                       : (ack ? ST_W_AACK : ST_W_ANACK));
      K_WDATA:  s = arb ? ST_ARB : (ack ? ST_W_DACK : ST_W_DNACK);
      K_RX:     s = ack ? ST_R_DACK : ST_R_DNACK;
      default:  s = ST_IDLE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/twm_qtick.sv
module twm_qtick #(
  parameter int QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

  logic [CW-1:0] cnt_q, cnt_n;
  logic          tick_q, tick_n;

  always_comb begin
    tick_n = (cnt_q == '0);
    cnt_n  = (cnt_q == '0) ? CW'(QDIV - 1) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      tick_q <= tick_n;
    end
  end

  assign tick = tick_q;

  generate
    if (QDIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q); // R4
    end
  endgenerate

endmodule

// File: rtl/twm_engine.sv
module twm_engine
  import twm_pkg::*;
#(
  parameter int BUS_FREE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  op_e        go_op,
  input  logic [7:0] go_byte,
  input  logic       go_ack,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       busy,
  output logic       own,
  output logic       done,
  output logic       res_arb,
  output logic       res_ack,
  output logic [7:0] res_byte,
  output logic       scl_low,
  output logic       sda_low
);
  localparam int FW = $clog2(BUS_FREE + 1);

  typedef enum logic [1:0] {E_IDLE, E_WAIT, E_RUN, E_HOLD} est_e;

  est_e          st_q, st_n;
  op_e           op_q, op_n;
  logic [1:0]    q_q, q_n;
  logic [3:0]    bit_q, bit_n;
  logic [7:0]    sh_q, sh_n;
  logic [FW-1:0] free_q, free_n;
  logic ackc_q, ackc_n, ack_q, ack_n, arb_q, arb_n;
  logic done_q, done_n, hold_q, hold_n, own_q, own_n;
  logic drv_sda, end_bit, last_bit, arb_hit;

  // SDA drive during the running bit, per quarter
  always_comb begin
    case (op_q)
      OP_START: drv_sda = (q_q == 2'd3);
      OP_STOP:  drv_sda = (q_q != 2'd3);
      OP_TX:    drv_sda = (bit_q < 4'd8) ? !sh_q[7] : 1'b0;
      default:  drv_sda = (bit_q == 4'd8) && ackc_q;
    endcase
  end

  assign end_bit  = tick && (q_q == 2'd3);
  assign last_bit = (op_q == OP_START) || (op_q == OP_STOP) || (bit_q == 4'd8);
  assign arb_hit  = end_bit && (op_q == OP_TX) && (bit_q < 4'd8) && sh_q[7] && !sda_in;

  always_comb begin
    st_n = st_q; op_n = op_q; q_n = q_q; bit_n = bit_q; sh_n = sh_q;
    free_n = free_q; ackc_n = ackc_q; ack_n = ack_q; arb_n = arb_q;
    hold_n = hold_q; own_n = own_q; done_n = 1'b0;
    case (st_q)
      E_IDLE, E_HOLD: begin
        if (go) begin
          op_n = go_op; sh_n = go_byte; ackc_n = go_ack;
          q_n = 2'd0; bit_n = 4'd0; free_n = '0;
          st_n = (go_op == OP_START && !own_q) ? E_WAIT : E_RUN;
        end
      end
      E_WAIT: begin
        if (tick) begin
          if (scl_in && sda_in) begin
            free_n = free_q + 1'b1;
            if (free_q == FW'(BUS_FREE - 1)) st_n = E_RUN;
          end else begin
            free_n = '0;
          end
        end
      end
      default: begin
        if (tick) q_n = q_q + 2'd1;
        if (end_bit) begin
          if (bit_q < 4'd8) sh_n = (op_q == OP_RX) ? {sh_q[6:0], sda_in} : {sh_q[6:0], 1'b0};
          if (op_q == OP_TX && bit_q == 4'd8) ack_n = !sda_in;
          if (op_q == OP_RX && bit_q == 4'd8) ack_n = ackc_q;
          if (last_bit) begin
            done_n = 1'b1; arb_n = 1'b0;
            if (op_q == OP_STOP) begin
              st_n = E_IDLE; own_n = 1'b0;
            end else begin
              st_n = E_HOLD; own_n = 1'b1; hold_n = drv_sda;
            end
          end else begin
            bit_n = bit_q + 4'd1;
          end
          if (arb_hit) begin
            st_n = E_IDLE; own_n = 1'b0; done_n = 1'b1; arb_n = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= E_IDLE; op_q <= OP_START; q_q <= '0; bit_q <= '0; sh_q <= '0;
      free_q <= '0; ackc_q <= 1'b0; ack_q <= 1'b0; arb_q <= 1'b0;
      hold_q <= 1'b0; own_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_n; op_q <= op_n; q_q <= q_n; bit_q <= bit_n; sh_q <= sh_n;
      free_q <= free_n; ackc_q <= ackc_n; ack_q <= ack_n; arb_q <= arb_n;
      hold_q <= hold_n; own_q <= own_n; done_q <= done_n;
    end
  end

  assign scl_low  = (st_q == E_RUN) ? !q_q[1] : (st_q == E_HOLD);
  assign sda_low  = (st_q == E_RUN) ? drv_sda : ((st_q == E_HOLD) && hold_q);
  assign busy     = (st_q == E_WAIT) || (st_q == E_RUN);
  assign own      = own_q;
  assign done     = done_q;
  assign res_arb  = arb_q;
  assign res_ack  = ack_q;
  assign res_byte = sh_q;

  AST_WAIT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_WAIT && tick && !(scl_in && sda_in)) |=> (st_q == E_WAIT)); // R4
  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && arb_q) |-> (!scl_low && !sda_low)); // R9

endmodule

// File: rtl/twm_master_rx.sv
module twm_master_rx
  import twm_pkg::*;
#(
  parameter int QDIV     = 4,
  parameter int BUS_FREE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       dat_wr,
  input  logic [7:0] dat_wdata,
  output logic [7:0] ctl_rdata,
  output logic [7:0] stat_rdata,
  output logic [7:0] dat_rdata,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low
);
  logic [1:0] rs_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  logic       tick;
  logic       eng_busy, eng_own, eng_done, eng_arb, eng_ack;
  logic [7:0] eng_byte;
  logic       fire, ctl_go;
  op_e        op_sel;
  kind_e      kind_sel, kind_q, kind_n;

  logic flag_q, flag_n, acken_q, acken_n, sta_q, sta_n, sto_q, sto_n;
  logic wcol_q, wcol_n, en_q, en_n, ie_q, ie_n, rd_q, rd_n;
  logic [7:0] stat_q, stat_n, dat_q, dat_n;
  logic unused_bits;

  assign unused_bits = ^{ctl_wdata[3], ctl_wdata[1]};

  twm_qtick #(.QDIV(QDIV)) u_tick (.clk(clk), .rst_n(arst_n), .tick(tick));

  twm_engine #(.BUS_FREE(BUS_FREE)) u_eng (
    .clk(clk), .rst_n(arst_n), .tick(tick),
    .go(fire), .go_op(op_sel), .go_byte(dat_q), .go_ack(ctl_wdata[6]),
    .scl_in(scl_in), .sda_in(sda_in),
    .busy(eng_busy), .own(eng_own), .done(eng_done), .res_arb(eng_arb),
    .res_ack(eng_ack), .res_byte(eng_byte), .scl_low(scl_low), .sda_low(sda_low)
  );

  assign ctl_go = ctl_wr && ctl_wdata[7] && ctl_wdata[2] && !eng_busy &&
                  (flag_q || stat_q == ST_IDLE);

  // Next bus action, picked from the request bits and the posted status
  always_comb begin
    fire = 1'b0; op_sel = OP_TX; kind_sel = K_ADDR;
    if (ctl_go) begin
      if (ctl_wdata[5]) begin
        fire = 1'b1; op_sel = OP_START; kind_sel = eng_own ? K_RSTART : K_START;
      end else if (ctl_wdata[4] && eng_own) begin
        fire = 1'b1; op_sel = OP_STOP; kind_sel = K_STOP;
      end else begin
        case (stat_q)
          ST_START, ST_RSTART: begin fire = 1'b1; op_sel = OP_TX; kind_sel = K_ADDR;  end
          ST_W_AACK, ST_W_DACK: begin fire = 1'b1; op_sel = OP_TX; kind_sel = K_WDATA; end
          ST_R_AACK, ST_R_DACK: begin fire = 1'b1; op_sel = OP_RX; kind_sel = K_RX;    end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    flag_n = flag_q; acken_n = acken_q; sta_n = sta_q; sto_n = sto_q;
    wcol_n = wcol_q; en_n = en_q; ie_n = ie_q; rd_n = rd_q;
    stat_n = stat_q; dat_n = dat_q; kind_n = kind_q;
    if (fire) begin
      kind_n = kind_sel;
      if (kind_sel == K_ADDR) rd_n = dat_q[0];
    end
    if (eng_done) begin
      stat_n = post_status(kind_q, eng_arb, eng_ack, rd_q);
      if (kind_q == K_RX) dat_n = eng_byte;
      if (kind_q == K_START || kind_q == K_RSTART) sta_n = 1'b0;
      if (kind_q == K_STOP) sto_n = 1'b0;
    end
    if (ctl_wr) begin
      acken_n = ctl_wdata[6]; sta_n = ctl_wdata[5]; sto_n = ctl_wdata[4];
      en_n = ctl_wdata[2]; ie_n = ctl_wdata[0];
      if (ctl_wdata[7]) flag_n = 1'b0;
    end
    if (eng_done && kind_q != K_STOP) flag_n = 1'b1;
    if (dat_wr) begin
      if (flag_q) begin
        dat_n = dat_wdata; wcol_n = 1'b0;
      end else begin
        wcol_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      flag_q <= 1'b0; acken_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0;
      wcol_q <= 1'b0; en_q <= 1'b0; ie_q <= 1'b0; rd_q <= 1'b0;
      stat_q <= ST_IDLE; dat_q <= 8'h00; kind_q <= K_START;
    end else begin
      flag_q <= flag_n; acken_q <= acken_n; sta_q <= sta_n; sto_q <= sto_n;
      wcol_q <= wcol_n; en_q <= en_n; ie_q <= ie_n; rd_q <= rd_n;
      stat_q <= stat_n; dat_q <= dat_n; kind_q <= kind_n;
    end
  end

  assign ctl_rdata  = {flag_q, acken_q, sta_q, sto_q, wcol_q, en_q, 1'b0, ie_q};
  assign stat_rdata = stat_q;
  assign dat_rdata  = dat_q;
  assign irq        = flag_q && ie_q;

  AST_SCL_HELD: assert property (@(posedge clk) disable iff (!arst_n)
    (flag_q && eng_own) |-> scl_low); // R11
  AST_WCOL_KEEP: assert property (@(posedge clk) disable iff (!arst_n)
    (dat_wr && !flag_q && !eng_done) |=> ($stable(dat_q) && wcol_q)); // R12
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!arst_n)
    (ctl_wr && ctl_wdata[7] && !eng_done) |=> !flag_q); // R3
  AST_FLAG_NOT_IDLE: assert property (@(posedge clk) disable iff (!arst_n)
    flag_q |-> (stat_q != ST_IDLE)); // R10

endmodule

// File: tb/sim_twm_master_rx.sv
`timescale 1ns/1ps
module sim_twm_master_rx;
  localparam logic [6:0] SLV = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0, dat_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00, dat_wdata = 8'h00;
  logic [7:0] ctl_rdata, stat_rdata, dat_rdata;
  logic irq, scl_low, m_sda_low;
  logic scl_bus, sda_bus;
  logic rival_low = 1'b0;
  logic sl_low, sl_wack = 1'b1;

  int checks = 0, errors = 0;
  int c_idx = 0;

  always #4 clk = ~clk;

  assign scl_bus = !scl_low;
  assign sda_bus = !(m_sda_low || sl_low || rival_low);

  twm_master_rx u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .ctl_rdata(ctl_rdata),
    .stat_rdata(stat_rdata), .dat_rdata(dat_rdata), .irq(irq),
    .scl_in(scl_bus), .sda_in(sda_bus), .scl_low(scl_low), .sda_low(m_sda_low)
  );

  function automatic logic [7:0] exp_byte(input int n);
    return 8'((n * 75 + 165) ^ (n << 3));
  endfunction

  function automatic logic [7:0] exp_addr_stat(input logic rd, input logic match);
    if (match) return rd ? 8'h40 : 8'h18;
    return rd ? 8'h48 : 8'h20;
  endfunction

  // ---------------- bus slave model ----------------
  logic sp_scl, sp_sda, m_ack;
  logic [1:0] sl_st; // 0 idle, 1 address, 2 slave sends, 3 slave receives
  int sl_rcv, sl_idx;
  logic [7:0] sl_sh, sl_tx, sl_got, nb;
  assign nb = exp_byte(sl_idx);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_scl <= 1'b1; sp_sda <= 1'b1; sl_st <= 2'd0; sl_rcv <= 0; sl_idx <= 0;
      sl_sh <= 8'h00; sl_tx <= 8'h00; sl_got <= 8'h00; sl_low <= 1'b0; m_ack <= 1'b0;
    end else begin
      sp_scl <= scl_bus; sp_sda <= sda_bus;
      if (scl_bus && sp_scl && sp_sda && !sda_bus) begin
        sl_st <= 2'd1; sl_rcv <= 0; sl_low <= 1'b0;
      end else if (scl_bus && sp_scl && !sp_sda && sda_bus) begin
        sl_st <= 2'd0; sl_low <= 1'b0;
      end else if (scl_bus && !sp_scl && sl_st != 2'd0) begin
        if (sl_rcv < 8 && sl_st != 2'd2) sl_sh <= {sl_sh[6:0], sda_bus};
        if (sl_rcv == 8 && sl_st == 2'd2) m_ack <= !sda_bus;
        sl_rcv <= sl_rcv + 1;
      end else if (!scl_bus && sp_scl && sl_st != 2'd0) begin
        if (sl_rcv == 8) begin
          case (sl_st)
            2'd1: sl_low <= (sl_sh[7:1] == SLV);
            2'd2: sl_low <= 1'b0;
            default: begin sl_low <= sl_wack; sl_got <= sl_sh; end
          endcase
        end else if (sl_rcv == 9) begin
          sl_rcv <= 0;
          if (sl_st == 2'd1) begin
            if (sl_sh[7:1] == SLV && sl_sh[0]) begin
              sl_st <= 2'd2; sl_tx <= nb; sl_low <= !nb[7]; sl_idx <= sl_idx + 1;
            end else if (sl_sh[7:1] == SLV) begin
              sl_st <= 2'd3; sl_low <= 1'b0;
            end else begin
              sl_st <= 2'd0; sl_low <= 1'b0;
            end
          end else if (sl_st == 2'd2) begin
            if (m_ack) begin
              sl_tx <= nb; sl_low <= !nb[7]; sl_idx <= sl_idx + 1;
            end else begin
              sl_st <= 2'd0; sl_low <= 1'b0;
            end
          end else begin
            sl_low <= 1'b0;
          end
        end else if (sl_st == 2'd2 && sl_rcv > 0) begin
          sl_low <= !sl_tx[3'(7 - sl_rcv)];
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic cpu_dat(input logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int n = 0;
    while (!ctl_rdata[7] && n < 5000) begin @(negedge clk); n++; end
    chk(ctl_rdata[7] == 1'b1, req, ctl_rdata[7], 1);
  endtask

  task automatic do_stop();
    int n = 0;
    cpu_ctl(8'h94);
    while (ctl_rdata[4] && n < 5000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk(stat_rdata == 8'hF8 && !ctl_rdata[7], "R10 status/flag after STOP",
        {ctl_rdata[7], stat_rdata}, 8'hF8);
    chk(scl_bus && sda_bus, "R10 lines released", {scl_bus, sda_bus}, 3);
  endtask

  task automatic do_start(input logic [7:0] exp);
    cpu_ctl(8'hA4);
    wait_flag("R4 flag after START");
    chk(stat_rdata == exp, (exp == 8'h10) ? "R5 repeated START status" : "R4 START status",
        stat_rdata, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic rd, match, last, was_ack;
    logic [7:0] b;
    int nby;
    void'($urandom(32'd5171));
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(stat_rdata == 8'hF8, "R2 reset status", stat_rdata, 8'hF8);
    chk(ctl_rdata == 8'h00 && dat_rdata == 8'h00, "R2 reset regs", {ctl_rdata, dat_rdata}, 0);
    chk(scl_bus && sda_bus && !irq, "R2 lines released", {scl_bus, sda_bus, irq}, 6);

    cpu_dat(8'h33);
    chk(ctl_rdata[3] && dat_rdata == 8'h00, "R12 write collision", {ctl_rdata[3], dat_rdata}, 9'h100);

    cpu_ctl(8'h47);
    chk(ctl_rdata == 8'h4D, "R1 control readback", ctl_rdata, 8'h4D);

    // START must wait for a free bus
    rival_low = 1'b1;
    cpu_ctl(8'hA5);
    repeat (120) @(negedge clk);
    chk(!ctl_rdata[7] && scl_bus, "R4 START held while SDA low", ctl_rdata[7], 0);
    rival_low = 1'b0;
    wait_flag("R4 flag after START");
    chk(stat_rdata == 8'h08, "R4 START status", stat_rdata, 8'h08);
    chk(!ctl_rdata[5], "R4 start bit self-clears", ctl_rdata[5], 0);
    chk(irq, "R1 irq = flag and enable", irq, 1);
    repeat (20) @(negedge clk);
    chk(!scl_bus, "R11 SCL held low with flag", scl_bus, 0);

    cpu_ctl(8'h04);
    chk(ctl_rdata[7] && stat_rdata == 8'h08, "R3 write without clear bit", {ctl_rdata[7], stat_rdata}, 9'h108);

    for (int t = 0; t < 8; t++) begin
      rd = 1'($urandom % 2);
      match = (($urandom % 4) != 0);
      b = {match ? SLV : (SLV ^ 7'h01), rd};
      cpu_dat(b);
      chk(!ctl_rdata[3] && dat_rdata == b, "R12 data load with flag", {ctl_rdata[3], dat_rdata}, b);
      cpu_ctl(8'h84);
      wait_flag("R6 flag after address");
      chk(stat_rdata == exp_addr_stat(rd, match), "R6 address status", stat_rdata, exp_addr_stat(rd, match));
      if (match && rd) begin
        nby = 1 + int'($urandom % 3);
        for (int k = 0; k < nby; k++) begin
          last = (k == nby - 1);
          cpu_ctl(last ? 8'h84 : 8'hC4);
          wait_flag("R7 flag after byte");
          chk(stat_rdata == (last ? 8'h58 : 8'h50), "R7 receive status", stat_rdata, last ? 8'h58 : 8'h50);
          chk(dat_rdata == exp_byte(c_idx), "R7 received byte", dat_rdata, exp_byte(c_idx));
          chk(m_ack == !last, "R7 acknowledge on bus", m_ack, !last);
          chk(!scl_bus, "R11 SCL held low with flag", scl_bus, 0);
          c_idx++;
        end
      end else if (match) begin
        nby = 1 + int'($urandom % 3);
        for (int k = 0; k < nby; k++) begin
          was_ack = 1'($urandom % 2);
          sl_wack = was_ack;
          b = 8'($urandom);
          cpu_dat(b);
          cpu_ctl(8'h84);
          wait_flag("R8 flag after byte");
          chk(stat_rdata == (was_ack ? 8'h28 : 8'h30), "R8 send status", stat_rdata, was_ack ? 8'h28 : 8'h30);
          chk(sl_got == b, "R8 byte seen by slave", sl_got, b);
          if (!was_ack) break;
        end
        sl_wack = 1'b1;
      end
      if (($urandom % 2) == 1) begin
        do_start(8'h10);
      end else begin
        do_stop();
        do_start(8'h08);
      end
    end

    // arbitration loss on the first address bit (a one)
    rival_low = 1'b1;
    cpu_dat({SLV, 1'b1});
    cpu_ctl(8'h84);
    wait_flag("R9 flag after loss");
    chk(stat_rdata == 8'h38, "R9 arbitration status", stat_rdata, 8'h38);
    repeat (10) @(negedge clk);
    chk(scl_bus, "R9 SCL released", scl_bus, 1);
    rival_low = 1'b0;
    do_start(8'h08);

    // directed read-address NACK
    cpu_dat({SLV ^ 7'h04, 1'b1});
    cpu_ctl(8'h84);
    wait_flag("R6 flag after address");
    chk(stat_rdata == 8'h48, "R6 read address NACK", stat_rdata, 8'h48);
    do_stop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule